// File: doc/BRIEF.md
# Instruction Cycle Micro-Operation Sequencer

This block is the control unit and register datapath of a small accumulator machine that runs multi-cycle. Each instruction goes through a fixed series of phases. A fetch phase always comes first. An indirect phase follows when the instruction asks for one. The execute phase comes next. An interrupt phase follows when an enabled request is pending. A 2-bit phase register and a timing-step counter select one group of register transfers per clock. The datapath holds the memory address register, the memory buffer register, the program counter, the instruction register and one accumulator.

The block drives a single-port, word-addressed memory. The memory address always comes from the memory address register, and the write data always comes from the memory buffer register. Read data is taken combinationally in the same step that captures it. Every 16-bit word has the same layout: bits 15:12 hold the opcode, bit 11 is the indirect flag, and bits 10:0 hold the address. The save address and the handler address used by the interrupt phase are parameters, with defaults 0x030 and 0x020. Reset is active low and asynchronous. Its release is expected to be synchronous to `clk`.

Top module: `instr_cycle_seq`

## Requirements
- R1: The `phase` output reads 00 in fetch, 01 in indirect, 10 in execute and 11 in interrupt. While reset is asserted, PC, phase, step, accumulator and `halted` are all zero.
- R2: Fetch lasts three clocks. In step 1 the address register loads PC. In step 2, `mem_rd` is high with `mem_addr` equal to the old PC, the buffer captures the memory word, and PC increments. In step 3 the instruction register loads the buffer.
- R3: The indirect phase runs only when bit 11 of the fetched word is set and the opcode is 0x1 to 0x5. It lasts three clocks: it reads the word at the address field, replaces the instruction's address field with bits 10:0 of that word, and always moves on to execute. Any other opcode with bit 11 set goes straight to execute.
- R4: LOAD (0x1) lasts three execute clocks and copies the addressed word into the accumulator. STORE (0x2) lasts two execute clocks and writes the accumulator to the addressed word.
- R5: ADD (0x3) lasts three execute clocks and adds the addressed word to the accumulator, modulo 2^16.
- R6: ISZ (0x4) lasts four execute clocks. It writes the addressed word plus one back to memory. When that new value is zero, PC advances by one more, which skips the next instruction.
- R7: JMP (0x5) lasts one execute clock and loads PC from the address field.
- R8: At the end of execute, if `irq` and `irq_en` are both high, a three-clock interrupt phase writes the PC to the save address, loads PC with the handler address, and then returns to fetch. If `irq_en` is low, the request has no effect.
- R9: HALT (0xF) sets `halted` after one execute clock. After that, PC, phase and step stay frozen, there is no memory access, and interrupts are refused until reset.
- R10: `mem_rd` and `mem_wr` are never high together. Opcodes 0x0 and 0x6 to 0xE take one execute clock and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 11 | Memory word address (the address register) |
| mem_rd | output | 1 | Read strobe; the buffer captures `mem_rdata` at the clock edge |
| mem_wr | output | 1 | Write strobe; memory stores `mem_wdata` at the clock edge |
| mem_wdata | output | 16 | Write data (the buffer register) |
| mem_rdata | input | 16 | Combinational read data for `mem_addr` |
| irq | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| phase | output | 2 | Current phase code |
| pc | output | 11 | Program counter |
| acc | output | 16 | Accumulator |
| halted | output | 1 | High after HALT until reset |

## Verification
Every phase has a fixed length, so the edge on which each result lands can be counted from reset release. Fetch takes 3 clocks, indirect 3, interrupt 3, and execute 1 to 4 depending on the opcode. The read strobe in fetch therefore appears after exactly one edge, and the indirect phase covers edges 3 to 5. A whole program reaches `halted` on a known edge: for example, 21 edges for LOAD, ADD, STORE, HALT. The bench samples on the falling edge and counts edges until `halted`. It compares that count, the accumulator, PC and memory against totals worked out by hand, so an extra or missing step in any phase shows up as a wrong count. Phase traces and the fetch strobe are sampled after the exact number of edges the requirements give.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_IND   = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INT   = 2'b11
  } phase_e;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OP_W-1:0] OP_ISZ   = 4'h4;
  localparam logic [OP_W-1:0] OP_JMP   = 4'h5;
  localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

  // one bit per register transfer issued in a step
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic mbr_from_pc;
    logic mbr_inc;
    logic ir_from_mbr;
    logic ir_addr_from_mbr;
    logic acc_from_mbr;
    logic acc_add_mbr;
    logic pc_inc;
    logic pc_skip_zero;
    logic pc_from_ir;
    logic pc_from_handler;
    logic mem_write;
  } uop_t;

  function automatic logic refs_memory(input logic [OP_W-1:0] op);
    return (op >= OP_LOAD) && (op <= OP_JMP);
  endfunction

endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   ir_op,
  input  logic [OP_W-1:0]   mbr_op,
  input  logic              mbr_ind,
  input  logic              irq,
  input  logic              irq_en,
  output phase_e            phase_q,
  output logic [STEP_W-1:0] step_q,
  output logic              halted_q,
  output uop_t              uop
);

  localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);

  logic   last_step;
  logic   halt_set;
  phase_e phase_d;
  logic [STEP_W-1:0] step_d;
  logic   seq_en;

  always_comb begin
    uop       = '0;
    last_step = 1'b0;
    halt_set  = 1'b0;
    phase_d   = phase_q;
    unique case (phase_q)
      PH_FETCH: begin
        unique case (step_q)
          S0:      uop.mar_from_pc = 1'b1;
          S1: begin
            uop.mbr_from_mem = 1'b1;
            uop.pc_inc       = 1'b1;
          end
          default: begin
            uop.ir_from_mbr = 1'b1;
            last_step       = 1'b1;
          end
        endcase
        phase_d = (mbr_ind && refs_memory(mbr_op)) ? PH_IND : PH_EXEC;
      end
      PH_IND: begin
        unique case (step_q)
          S0:      uop.mar_from_ir = 1'b1;
          S1:      uop.mbr_from_mem = 1'b1;
          default: begin
            uop.ir_addr_from_mbr = 1'b1;
            last_step            = 1'b1;
          end
        endcase
        phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        phase_d = (irq && irq_en) ? PH_INT : PH_FETCH;
        unique case (ir_op)
          OP_LOAD, OP_ADD: begin
            unique case (step_q)
              S0:      uop.mar_from_ir = 1'b1;
              S1:      uop.mbr_from_mem = 1'b1;
              default: begin
                uop.acc_from_mbr = (ir_op == OP_LOAD);
                uop.acc_add_mbr  = (ir_op == OP_ADD);
                last_step        = 1'b1;
              end
            endcase
          end
          OP_STORE: begin
            if (step_q == S0) begin
              uop.mar_from_ir  = 1'b1;
              uop.mbr_from_acc = 1'b1;
            end else begin
              uop.mem_write = 1'b1;
              last_step     = 1'b1;
            end
          end
          OP_ISZ: begin
            unique case (step_q)
              S0: uop.mar_from_ir = 1'b1;
              S1: uop.mbr_from_mem = 1'b1;
              S2: uop.mbr_inc = 1'b1;
              S3: begin
                uop.mem_write    = 1'b1;
                uop.pc_skip_zero = 1'b1;
                last_step        = 1'b1;
              end
              default: last_step = 1'b1;
            endcase
          end
          OP_JMP: begin
            uop.pc_from_ir = 1'b1;
            last_step      = 1'b1;
          end
          OP_HALT: halt_set = 1'b1;
          default: last_step = 1'b1;
        endcase
      end
      default: begin
        unique case (step_q)
          S0:      uop.mbr_from_pc = 1'b1;
          S1: begin
            uop.mar_from_save   = 1'b1;
            uop.pc_from_handler = 1'b1;
          end
          default: begin
            uop.mem_write = 1'b1;
            last_step     = 1'b1;
          end
        endcase
        phase_d = PH_FETCH;
      end
    endcase
  end

  assign seq_en = !halted_q && !halt_set;
  assign step_d = last_step ? S0 : step_q + S1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_FETCH;
      step_q   <= S0;
      halted_q <= 1'b0;
    end else begin
      if (halt_set) halted_q <= 1'b1;
      if (seq_en) begin
        step_q <= step_d;
        if (last_step) phase_q <= phase_d;
      end
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = AW + OP_W + 1,
  parameter logic [AW-1:0] SAVE_ADDR    = '0,
  parameter logic [AW-1:0] HANDLER_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  uop_t            uop,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [OP_W-1:0] ir_op,
  output logic [OP_W-1:0] mbr_op,
  output logic            mbr_ind,
  output logic [AW-1:0]   pc_q,
  output logic [DW-1:0]   acc_q
);

  localparam int IND_BIT = AW;

  logic [AW-1:0] mar_q, mar_d, pc_d;
  logic [DW-1:0] mbr_q, mbr_d, ir_q, ir_d, acc_d;
  logic          mar_en, mbr_en, ir_en, acc_en, pc_en;
  logic          skip_now;

  always_comb begin
    mar_en = uop.mar_from_pc | uop.mar_from_ir | uop.mar_from_save;
    if (uop.mar_from_pc)      mar_d = pc_q;
    else if (uop.mar_from_ir) mar_d = ir_q[AW-1:0];
    else                      mar_d = SAVE_ADDR;

    mbr_en = uop.mbr_from_mem | uop.mbr_from_acc | uop.mbr_from_pc | uop.mbr_inc;
    if (uop.mbr_from_mem)      mbr_d = mem_rdata;
    else if (uop.mbr_from_acc) mbr_d = acc_q;
    else if (uop.mbr_from_pc)  mbr_d = {{(DW-AW){1'b0}}, pc_q};
    else                       mbr_d = mbr_q + DW'(1);

    ir_en = uop.ir_from_mbr | uop.ir_addr_from_mbr;
    ir_d  = uop.ir_from_mbr ? mbr_q : {ir_q[DW-1:AW], mbr_q[AW-1:0]};

    acc_en = uop.acc_from_mbr | uop.acc_add_mbr;
    acc_d  = uop.acc_from_mbr ? mbr_q : acc_q + mbr_q;

    skip_now = uop.pc_skip_zero && (mbr_q == '0);
    pc_en    = uop.pc_inc | skip_now | uop.pc_from_ir | uop.pc_from_handler;
    if (uop.pc_from_ir)           pc_d = ir_q[AW-1:0];
    else if (uop.pc_from_handler) pc_d = HANDLER_ADDR;
    else                          pc_d = pc_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      pc_q  <= '0;
    end else begin
      if (mar_en) mar_q <= mar_d;
      if (mbr_en) mbr_q <= mbr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (acc_en) acc_q <= acc_d;
      if (pc_en)  pc_q  <= pc_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = uop.mbr_from_mem;
  assign mem_wr    = uop.mem_write;
  assign ir_op     = ir_q[DW-1 -: OP_W];
  assign mbr_op    = mbr_q[DW-1 -: OP_W];
  assign mbr_ind   = mbr_q[IND_BIT];

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 11'h030,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h020
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [ADDR_W+OP_W:0]      mem_wdata,
  input  logic [ADDR_W+OP_W:0]      mem_rdata,
  input  logic                      irq,
  input  logic                      irq_en,
  output logic [1:0]                phase,
  output logic [ADDR_W-1:0]         pc,
  output logic [ADDR_W+OP_W:0]      acc,
  output logic                      halted
);

  localparam int DATA_W = ADDR_W + OP_W + 1;
  localparam int STEP_W = 2;

  uop_t              uop;
  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic [OP_W-1:0]   ir_op, mbr_op;
  logic              mbr_ind;

  seq_control #(.STEP_W(STEP_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_op    (ir_op),
    .mbr_op   (mbr_op),
    .mbr_ind  (mbr_ind),
    .irq      (irq),
    .irq_en   (irq_en),
    .phase_q  (phase_q),
    .step_q   (step_q),
    .halted_q (halted),
    .uop      (uop)
  );

  seq_datapath #(
    .AW           (ADDR_W),
    .DW           (DATA_W),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ir_op     (ir_op),
    .mbr_op    (mbr_op),
    .mbr_ind   (mbr_ind),
    .pc_q      (pc),
    .acc_q     (acc)
  );

  assign phase = phase_q;

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int AW = 11,
  parameter logic [AW-1:0] SAVE_ADDR = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic [1:0]    step_q,
  input logic          halted,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr
);

  AST_FETCH_PC_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && step_q == 2'd1 && !halted) |=> (pc == AW'($past(pc) + AW'(1)))); // R2

  AST_IND_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01 && step_q == 2'd2) |=> (phase == 2'b10 && step_q == 2'd0)); // R3

  AST_INT_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && step_q == 2'd2) |=> (phase == 2'b00 && step_q == 2'd0)); // R8

  AST_INT_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && step_q == 2'd2) |-> (mem_wr && mem_addr == SAVE_ADDR)); // R8

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(phase) && $stable(step_q) && !mem_rd && !mem_wr)); // R9

  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

endmodule

bind instr_cycle_seq seq_checker #(.AW(ADDR_W), .SAVE_ADDR(SAVE_ADDR)) u_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .step_q   (step_q),
  .halted   (halted),
  .pc       (pc),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/test_instr_cycle_seq.sv
module test_instr_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        irq = 1'b0, irq_en = 1'b0;
  logic [1:0]  phase;
  logic [10:0] pc;
  logic [15:0] acc;
  logic        halted;

  logic        ld_en = 1'b0;
  logic [10:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [0:2047];

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  instr_cycle_seq i_instr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .irq_en(irq_en),
    .phase(phase), .pc(pc), .acc(acc), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  // w0..w3 at 0..3, word@0x40, word@0x41, exp acc, exp word@0x40, exp pc, exp edges to halt
  localparam logic [15:0] VEC [7][10] = '{
    '{16'h1040, 16'h3041, 16'h2040, 16'hF000, 16'h0005, 16'h0007, 16'h000C, 16'h000C, 16'h0004, 16'd21},
    '{16'h4040, 16'hF000, 16'h1040, 16'hF000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'd17},
    '{16'h4040, 16'h1040, 16'hF000, 16'h0000, 16'h0009, 16'h0000, 16'h000A, 16'h000A, 16'h0003, 16'd17},
    '{16'h1841, 16'h3040, 16'hF000, 16'h0000, 16'h1234, 16'h0040, 16'h2468, 16'h1234, 16'h0003, 16'd19},
    '{16'h1040, 16'h5003, 16'h3040, 16'hF000, 16'h0011, 16'h0000, 16'h0011, 16'h0011, 16'h0004, 16'd14},
    '{16'h1041, 16'h2841, 16'hF000, 16'h0000, 16'h7777, 16'h0040, 16'h0040, 16'h0040, 16'h0003, 16'd18},
    '{16'h0840, 16'hF000, 16'h0000, 16'h0000, 16'h5555, 16'h0000, 16'h0000, 16'h5555, 16'h0002, 16'd8}
  };
  localparam string VTAG [7] = '{"R4 R5", "R6 skip", "R6 noskip", "R3 R5", "R7", "R3 R4", "R3 R10"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_prog(input logic [15:0] w0, w1, w2, w3, m40, m41);
    rst_n = 1'b0;
    put(11'h000, w0); put(11'h001, w1); put(11'h002, w2); put(11'h003, w3);
    put(11'h020, 16'h0000); put(11'h030, 16'h0000);
    put(11'h040, m40); put(11'h041, m41);
    @(negedge clk);
  endtask

  task automatic run_to_halt(output int edges);
    edges = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!halted && edges < 400) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int edges;

    // reset state, R1
    load_prog(16'h1841, 16'h3040, 16'hF000, 16'h0000, 16'h1234, 16'h0040);
    check("R1 reset pc", 32'(pc), 32'h0);
    check("R1 reset phase", 32'(phase), 32'h0);
    check("R1 reset halted", 32'(halted), 32'h0);
    check("R1 reset acc", 32'(acc), 32'h0);

    // phase trace of an indirect LOAD, R1 R2 R3
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 9; k++) begin
      logic [1:0] exp_ph;
      exp_ph = (k < 3) ? 2'b00 : (k < 6) ? 2'b01 : 2'b10;
      check($sformatf("R1 R3 phase after %0d edges", k), 32'(phase), 32'(exp_ph));
      if (k == 1) begin
        check("R2 fetch read strobe", 32'(mem_rd), 32'h1);
        check("R2 fetch address", 32'(mem_addr), 32'h0);
      end
      if (k == 2) check("R2 pc after fetch read", 32'(pc), 32'h1);
      @(negedge clk);
    end

    // vector table walk
    for (int v = 0; v < 7; v++) begin
      load_prog(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      run_to_halt(edges);
      check({VTAG[v], " acc"}, 32'(acc), 32'(VEC[v][6]));
      check({VTAG[v], " word 0x40"}, 32'(mem[11'h040]), 32'(VEC[v][7]));
      check({VTAG[v], " pc"}, 32'(pc), 32'(VEC[v][8]));
      check({VTAG[v], " edges"}, 32'(edges), 32'(VEC[v][9]));
    end

    // interrupt taken after LOAD, R8
    load_prog(16'h1040, 16'hF000, 16'h0000, 16'h0000, 16'h00AB, 16'h0000);
    put(11'h020, 16'hF000);
    irq = 1'b1; irq_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 interrupt phase code", 32'(phase), 32'h3);
    edges = 6;
    while (!halted && edges < 400) begin
      @(negedge clk);
      edges++;
    end
    check("R8 saved pc", 32'(mem[11'h030]), 32'h1);
    check("R8 handler pc", 32'(pc), 32'h21);
    check("R8 acc", 32'(acc), 32'hAB);
    check("R8 edges", 32'(edges), 32'd13);

    // request with enable low is ignored, R8
    irq_en = 1'b0;
    load_prog(16'h1040, 16'hF000, 16'h0000, 16'h0000, 16'h00AB, 16'h0000);
    put(11'h020, 16'hF000);
    run_to_halt(edges);
    check("R8 disabled save word", 32'(mem[11'h030]), 32'h0);
    check("R8 disabled pc", 32'(pc), 32'h2);
    check("R8 disabled edges", 32'(edges), 32'd10);

    // halted machine refuses interrupt, R9
    irq_en = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 frozen pc", 32'(pc), 32'h2);
    check("R9 frozen phase", 32'(phase), 32'h2);
    check("R9 still halted", 32'(halted), 32'h1);
    check("R9 no save write", 32'(mem[11'h030]), 32'h0);
    irq = 1'b0; irq_en = 1'b0;

    // reset clears a halted machine, R1
    rst_n = 1'b0;
    #1;
    check("R1 reset after halt", 32'({halted, phase, pc}), 32'h0);
    check("R1 reset acc after halt", 32'(acc), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule